// File: doc/BRIEF.md
# TDM PCM Time-Slot Router

This block is the slot switch of a serial time-division PCM port. A frame holds 32, 64 or 128 byte-wide slots, sent eight bits per slot with the most significant bit first. Two serial data pins share the bus, and each pin can be driven or left released independently. The block is timed by a bit clock and a frame-sync pulse. Both are sampled in the system clock domain and must be synchronous to it. Data is launched on the rising edge of the bit clock and captured on the falling edge.

A configuration table holds one transmit word and one receive word for every slot. The transmit word chooses a source channel out of 32 channel byte registers, says whether that byte is fetched, and sets the output enable of each pin. The receive word chooses where the slot's bits come from: pin 1, pin 2, or the block's own outgoing stream as an internal loop. It also names the destination channel and says whether the byte is stored.

Host writes to the table go into a shadow copy. The shadow is moved into the working copy at each frame start, so a routing change never lands partway through a frame. The host loads transmit bytes through a write port and reads received bytes through a read port.

Top module: `pcm_slot_router`

## Requirements
- R1: After reset both pin output enables are 0 and every receive channel register reads 0. Until the first frame sync is seen, no pin is driven and nothing is received.
- R2: The mode input sets the slot count: 0 gives 32 slots, 1 gives 64, and 2 or 3 gives 128. Without a frame sync, the slot after the last one is slot 0. A frame sync seen on a bit-clock rise forces slot 0, bit 0 at any point in the frame.
- R3: The transmit word has this layout: bit 7 is the read enable, bit 6 enables pin 2, bit 5 enables pin 1, and bits 4:0 are the channel. When the read enable is set, the slot carries the byte of that channel register, most significant bit first. One bit is sent per bit-clock rise, and a slot is 8 bits.
- R4: When the transmit read enable is clear, no channel byte is fetched and the slot carries 8'hFF.
- R5: Output enable bit 0 drives pin 1 and bit 1 drives pin 2. Neither, either or both pins may be enabled in a slot. The enables change only at slot boundaries.
- R6: When both pins are enabled in a slot, they carry the same byte.
- R7: The receive word has this layout: bit 7 is the write enable, bits 6:5 are the source, and bits 4:0 are the destination channel. Source 01 takes the internal loop of the outgoing stream, 10 takes pin 1 and 11 takes pin 2. Bits are sampled on bit-clock falls, and the assembled byte is written to the destination channel after the eighth bit.
- R8: A receive slot with the write enable clear, or with source 00, writes no channel register.
- R9: A table write takes effect from the next frame start, whether that start comes from a frame sync or from the slot counter wrapping. Slots later in the current frame keep their old routing.
- R10: The host port writes the transmit channel registers. The read port returns the received byte of the indexed channel in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| mode_i | input | 2 | Slot count select |
| bclk_i | input | 1 | Bit clock, synchronous to clk_i |
| fsync_i | input | 1 | Frame sync, sampled on bit-clock rise |
| pin_i | input | 2 | Serial input from pin 1 (bit 0) and pin 2 (bit 1) |
| pin_o | output | 2 | Serial output data per pin |
| pin_oe_o | output | 2 | Output enable per pin |
| cfg_we_i | input | 1 | Table write strobe |
| cfg_slot_i | input | 7 | Slot index of the table write |
| cfg_dir_i | input | 1 | 0 selects the transmit word, 1 the receive word |
| cfg_data_i | input | 8 | Table word |
| ch_we_i | input | 1 | Transmit channel register write strobe |
| ch_wr_idx_i | input | 5 | Transmit channel index |
| ch_wr_data_i | input | 8 | Transmit channel byte |
| ch_rd_idx_i | input | 5 | Receive channel read index |
| ch_rd_data_o | output | 8 | Receive channel byte |

## Verification
Transmit slots are tried with each of the four output-enable patterns and with distinct channel bytes, so a swapped pin, a wrong bit order or a wrong channel fetch gives a different byte. Receive slots take distinct bytes on the two pins in the same slot, so a swapped source select is visible. The loop source is tried with a byte that appears on neither pin. Disabled slots, one with the write enable clear and one with source 00, are checked to leave their destination registers at zero. Slot-count wrapping is checked in each mode at the first slot beyond the shorter frame. A table write issued mid-frame is checked to leave the rest of that frame unchanged and to change the next frame.

// File: rtl/pcm_router_pkg.sv
package pcm_router_pkg;

  localparam int BYTE_W = 8;
  localparam int CH_FIELD_W = 5;

  typedef struct packed {
    logic                  rd_en;
    logic [1:0]            oe;    // [0] pin 1, [1] pin 2
    logic [CH_FIELD_W-1:0] ch;
  } tx_cfg_t;

  typedef struct packed {
    logic                  wr_en;
    logic [1:0]            src;
    logic [CH_FIELD_W-1:0] ch;
  } rx_cfg_t;

  localparam logic [1:0] SRC_OFF  = 2'b00;
  localparam logic [1:0] SRC_LOOP = 2'b01;
  localparam logic [1:0] SRC_PIN1 = 2'b10;
  localparam logic [1:0] SRC_PIN2 = 2'b11;

  localparam logic [BYTE_W-1:0] IDLE_BYTE = 8'hFF;

endpackage

// File: rtl/pcm_slot_timer.sv
module pcm_slot_timer #(
  parameter int NUM_SLOTS = 128,
  localparam int SLOT_W = $clog2(NUM_SLOTS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bclk_i,
  input  logic              fsync_i,
  input  logic [1:0]        mode_i,
  output logic              go_o,
  output logic              fall_o,
  output logic              slot_start_o,
  output logic              frame_start_o,
  output logic [2:0]        bit_o,
  output logic [SLOT_W-1:0] nxt_slot_o,
  output logic              synced_o
);

  logic              bclk_q, synced_q, rise;
  logic [2:0]        bit_q, nxt_bit;
  logic [SLOT_W-1:0] slot_q, nxt_slot, last_slot;
  int                lim;

  assign rise   = bclk_i & ~bclk_q;
  assign fall_o = ~bclk_i & bclk_q;
  assign go_o   = rise & (synced_q | fsync_i);

  always_comb begin
    lim = 32 << mode_i;
    if (lim > NUM_SLOTS) lim = NUM_SLOTS;
    last_slot = SLOT_W'(lim - 1);
  end

  always_comb begin
    if (fsync_i) begin
      nxt_bit  = '0;
      nxt_slot = '0;
    end else if (bit_q == 3'd7) begin
      nxt_bit  = '0;
      nxt_slot = (slot_q >= last_slot) ? '0 : slot_q + 1'b1;
    end else begin
      nxt_bit  = bit_q + 3'd1;
      nxt_slot = slot_q;
    end
  end

  assign slot_start_o  = go_o & (nxt_bit == 3'd0);
  assign frame_start_o = slot_start_o & (nxt_slot == '0);
  assign bit_o         = bit_q;
  assign nxt_slot_o    = nxt_slot;
  assign synced_o      = synced_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bclk_q   <= 1'b0;
      synced_q <= 1'b0;
      bit_q    <= 3'd7;
      slot_q   <= '0;
    end else begin
      bclk_q <= bclk_i;
      if (rise && fsync_i) synced_q <= 1'b1;
      if (go_o) begin
        bit_q  <= nxt_bit;
        slot_q <= nxt_slot;
      end
    end
  end

  a_r2_fsync_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rise && fsync_i) |=> (bit_q == 3'd0 && slot_q == '0));

  a_r2_bit_advance: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rise && !fsync_i && synced_q) |=> (bit_q == $past(bit_q) + 3'd1));

endmodule

// File: rtl/pcm_cfg_table.sv
module pcm_cfg_table
  import pcm_router_pkg::*;
#(
  parameter int NUM_SLOTS = 128,
  localparam int SLOT_W = $clog2(NUM_SLOTS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [SLOT_W-1:0] wr_slot_i,
  input  logic              wr_dir_i,
  input  logic [BYTE_W-1:0] wr_data_i,
  input  logic              frame_start_i,
  input  logic [SLOT_W-1:0] rd_slot_i,
  output tx_cfg_t           tx_cfg_o,
  output rx_cfg_t           rx_cfg_o
);

  logic [NUM_SLOTS-1:0][BYTE_W-1:0] sh_tx, sh_rx, act_tx, act_rx;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_tx <= '0;
      sh_rx <= '0;
    end else if (wr_en_i) begin
      if (wr_dir_i) sh_rx[wr_slot_i] <= wr_data_i;
      else          sh_tx[wr_slot_i] <= wr_data_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_tx <= '0;
      act_rx <= '0;
    end else if (frame_start_i) begin
      act_tx <= sh_tx;
      act_rx <= sh_rx;
    end
  end

  // the frame-start lookup already sees the shadow it is about to commit
  assign tx_cfg_o = tx_cfg_t'(frame_start_i ? sh_tx[rd_slot_i] : act_tx[rd_slot_i]);
  assign rx_cfg_o = rx_cfg_t'(frame_start_i ? sh_rx[rd_slot_i] : act_rx[rd_slot_i]);

  a_r9_active_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !frame_start_i |=> ($stable(act_tx) && $stable(act_rx)));

endmodule

// File: rtl/pcm_chan_regs.sv
module pcm_chan_regs
  import pcm_router_pkg::*;
#(
  parameter int NUM_CH = 32,
  localparam int CH_W = $clog2(NUM_CH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              host_we_i,
  input  logic [CH_W-1:0]   host_idx_i,
  input  logic [BYTE_W-1:0] host_data_i,
  input  logic [CH_W-1:0]   tx_idx_i,
  output logic [BYTE_W-1:0] tx_byte_o,
  input  logic              rx_we_i,
  input  logic [CH_W-1:0]   rx_idx_i,
  input  logic [BYTE_W-1:0] rx_data_i,
  input  logic [CH_W-1:0]   rd_idx_i,
  output logic [BYTE_W-1:0] rd_data_o
);

  logic [NUM_CH-1:0][BYTE_W-1:0] tx_q, rx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        tx_q <= '0;
    else if (host_we_i) tx_q[host_idx_i] <= host_data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      rx_q <= '0;
    else if (rx_we_i) rx_q[rx_idx_i] <= rx_data_i;
  end

  assign tx_byte_o = tx_q[tx_idx_i];
  assign rd_data_o = rx_q[rd_idx_i];

  a_r8_rx_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rx_we_i |=> $stable(rx_q));

endmodule

// File: rtl/pcm_slot_router.sv
module pcm_slot_router
  import pcm_router_pkg::*;
#(
  parameter int NUM_SLOTS = 128,
  parameter int NUM_CH = 32,
  localparam int SLOT_W = $clog2(NUM_SLOTS),
  localparam int CH_W = $clog2(NUM_CH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [1:0]        mode_i,
  input  logic              bclk_i,
  input  logic              fsync_i,
  input  logic [1:0]        pin_i,
  output logic [1:0]        pin_o,
  output logic [1:0]        pin_oe_o,
  input  logic              cfg_we_i,
  input  logic [SLOT_W-1:0] cfg_slot_i,
  input  logic              cfg_dir_i,
  input  logic [BYTE_W-1:0] cfg_data_i,
  input  logic              ch_we_i,
  input  logic [CH_W-1:0]   ch_wr_idx_i,
  input  logic [BYTE_W-1:0] ch_wr_data_i,
  input  logic [CH_W-1:0]   ch_rd_idx_i,
  output logic [BYTE_W-1:0] ch_rd_data_o
);

  logic              go, fall, slot_start, frame_start, synced;
  logic [2:0]        bit_idx;
  logic [SLOT_W-1:0] nxt_slot;
  tx_cfg_t           tx_cfg;
  rx_cfg_t           rx_cfg, rx_cfg_q;
  logic [BYTE_W-1:0] tx_chan_byte, tx_fetch, tx_sh, rx_sh, rx_byte;
  logic [1:0]        oe_q;
  logic              in_bit, rx_we;

  pcm_slot_timer #(.NUM_SLOTS(NUM_SLOTS)) u_timer (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .bclk_i       (bclk_i),
    .fsync_i      (fsync_i),
    .mode_i       (mode_i),
    .go_o         (go),
    .fall_o       (fall),
    .slot_start_o (slot_start),
    .frame_start_o(frame_start),
    .bit_o        (bit_idx),
    .nxt_slot_o   (nxt_slot),
    .synced_o     (synced)
  );

  pcm_cfg_table #(.NUM_SLOTS(NUM_SLOTS)) u_cfg (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .wr_en_i      (cfg_we_i),
    .wr_slot_i    (cfg_slot_i),
    .wr_dir_i     (cfg_dir_i),
    .wr_data_i    (cfg_data_i),
    .frame_start_i(frame_start),
    .rd_slot_i    (nxt_slot),
    .tx_cfg_o     (tx_cfg),
    .rx_cfg_o     (rx_cfg)
  );

  pcm_chan_regs #(.NUM_CH(NUM_CH)) u_chan (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .host_we_i  (ch_we_i),
    .host_idx_i (ch_wr_idx_i),
    .host_data_i(ch_wr_data_i),
    .tx_idx_i   (CH_W'(tx_cfg.ch)),
    .tx_byte_o  (tx_chan_byte),
    .rx_we_i    (rx_we),
    .rx_idx_i   (CH_W'(rx_cfg_q.ch)),
    .rx_data_i  (rx_byte),
    .rd_idx_i   (ch_rd_idx_i),
    .rd_data_o  (ch_rd_data_o)
  );

  assign tx_fetch = tx_cfg.rd_en ? tx_chan_byte : IDLE_BYTE;

  // transmit: load at slot start, shift out MSB first on each later rise
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_sh    <= IDLE_BYTE;
      oe_q     <= '0;
      rx_cfg_q <= '0;
    end else if (slot_start) begin
      tx_sh    <= tx_fetch;
      oe_q     <= tx_cfg.oe;
      rx_cfg_q <= rx_cfg;
    end else if (go) begin
      tx_sh <= {tx_sh[BYTE_W-2:0], 1'b1};
    end
  end

  assign pin_o    = {2{tx_sh[BYTE_W-1]}};
  assign pin_oe_o = oe_q;

  // receive
  always_comb begin
    unique case (rx_cfg_q.src)
      SRC_LOOP: in_bit = tx_sh[BYTE_W-1];
      SRC_PIN1: in_bit = pin_i[0];
      SRC_PIN2: in_bit = pin_i[1];
      default:  in_bit = 1'b0;
    endcase
  end

  assign rx_byte = {rx_sh[BYTE_W-2:0], in_bit};
  assign rx_we   = fall && synced && (bit_idx == 3'd7) &&
                   rx_cfg_q.wr_en && (rx_cfg_q.src != SRC_OFF);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             rx_sh <= '0;
    else if (fall && synced) rx_sh <= rx_byte;
  end

  a_r5_oe_at_boundary: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !slot_start |=> $stable(pin_oe_o));

endmodule

// File: tb/tb_pcm_slot_router.sv
module tb_pcm_slot_router;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic [1:0] mode = 2'd0;
  logic       bclk = 1'b0, fsync = 1'b0;
  logic [1:0] pin_i = '0;
  logic [1:0] pin_o, pin_oe;
  logic       cfg_we = 1'b0, cfg_dir = 1'b0;
  logic [6:0] cfg_slot = '0;
  logic [7:0] cfg_data = '0;
  logic       ch_we = 1'b0;
  logic [4:0] ch_wr_idx = '0, ch_rd_idx = '0;
  logic [7:0] ch_wr_data = '0, ch_rd_data;

  int errors = 0;
  int checks = 0;
  logic done = 1'b0;

  always #5 clk = ~clk;

  pcm_slot_router dut (
    .clk_i(clk), .rst_ni(rst_ni), .mode_i(mode), .bclk_i(bclk), .fsync_i(fsync),
    .pin_i(pin_i), .pin_o(pin_o), .pin_oe_o(pin_oe),
    .cfg_we_i(cfg_we), .cfg_slot_i(cfg_slot), .cfg_dir_i(cfg_dir), .cfg_data_i(cfg_data),
    .ch_we_i(ch_we), .ch_wr_idx_i(ch_wr_idx), .ch_wr_data_i(ch_wr_data),
    .ch_rd_idx_i(ch_rd_idx), .ch_rd_data_o(ch_rd_data)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cfg_write(input logic [6:0] slot, input logic dir, input logic [7:0] data);
    @(negedge clk);
    cfg_we = 1'b1; cfg_slot = slot; cfg_dir = dir; cfg_data = data;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic ch_write(input logic [4:0] idx, input logic [7:0] data);
    @(negedge clk);
    ch_we = 1'b1; ch_wr_idx = idx; ch_wr_data = data;
    @(negedge clk);
    ch_we = 1'b0;
  endtask

  task automatic ch_read(input logic [4:0] idx, output logic [7:0] data);
    @(negedge clk);
    ch_rd_idx = idx;
    #1 data = ch_rd_data;
  endtask

  // one slot of 8 bits; b1/b2 drive pin 1/pin 2, o1/o2 capture pin_o, oe mid-slot
  task automatic run_slot(input logic fs, input logic [7:0] b1, input logic [7:0] b2,
                          output logic [7:0] o1, output logic [7:0] o2, output logic [1:0] oe);
    for (int i = 7; i >= 0; i--) begin
      @(negedge clk);
      bclk = 1'b1; fsync = fs && (i == 7); pin_i = {b2[i], b1[i]};
      @(negedge clk);
      o1[i] = pin_o[0]; o2[i] = pin_o[1];
      if (i == 4) oe = pin_oe;
      bclk = 1'b0;
      @(negedge clk);
      fsync = 1'b0;
    end
  endtask

  task automatic idle_slots(input int n);
    logic [7:0] a, b; logic [1:0] e;
    for (int k = 0; k < n; k++) run_slot(1'b0, 8'h00, 8'h00, a, b, e);
  endtask

  task automatic t_reset();
    logic [7:0] a, b, d; logic [1:0] e;
    check("R1 oe after reset", {6'd0, pin_oe}, 8'h00);
    ch_read(5'd0, d);  check("R1 rx ch0 after reset", d, 8'h00);
    ch_read(5'd31, d); check("R1 rx ch31 after reset", d, 8'h00);
    ch_write(5'd1, 8'hA5);
    cfg_write(7'd0, 1'b0, 8'hA1);
    run_slot(1'b0, 8'h00, 8'h00, a, b, e);
    check("R1 no drive before sync", {6'd0, e}, 8'h00);
  endtask

  task automatic t_tx_basic();
    logic [7:0] a, b; logic [1:0] e;
    ch_write(5'd2, 8'h3C); ch_write(5'd3, 8'h81); ch_write(5'd4, 8'h7E);
    cfg_write(7'd1, 1'b0, 8'hC2); // pin 2, ch2
    cfg_write(7'd2, 1'b0, 8'hE3); // both, ch3
    cfg_write(7'd3, 1'b0, 8'h84); // none, ch4
    cfg_write(7'd4, 1'b0, 8'h21); // pin 1, read disabled
    run_slot(1'b1, 8'h00, 8'h00, a, b, e);
    check("R5 slot0 oe pin1", {6'd0, e}, 8'h01);
    check("R3 slot0 data ch1", a, 8'hA5);
    run_slot(1'b0, 8'h00, 8'h00, a, b, e);
    check("R5 slot1 oe pin2", {6'd0, e}, 8'h02);
    check("R3 slot1 data ch2", b, 8'h3C);
    run_slot(1'b0, 8'h00, 8'h00, a, b, e);
    check("R5 slot2 oe both", {6'd0, e}, 8'h03);
    check("R6 slot2 pin1 data", a, 8'h81);
    check("R6 slot2 pin2 data", b, 8'h81);
    run_slot(1'b0, 8'h00, 8'h00, a, b, e);
    check("R5 slot3 oe none", {6'd0, e}, 8'h00);
    run_slot(1'b0, 8'h00, 8'h00, a, b, e);
    check("R4 slot4 oe", {6'd0, e}, 8'h01);
    check("R4 slot4 idle byte", a, 8'hFF);
    idle_slots(27);
  endtask

  task automatic t_rx();
    logic [7:0] a, b, d; logic [1:0] e;
    cfg_write(7'd5, 1'b1, 8'hCA); // pin1 -> ch10
    cfg_write(7'd6, 1'b1, 8'hEB); // pin2 -> ch11
    cfg_write(7'd7, 1'b0, 8'h82); // tx ch2, no oe
    cfg_write(7'd7, 1'b1, 8'hAC); // loop -> ch12
    cfg_write(7'd8, 1'b1, 8'h8D); // src off, wen -> ch13
    cfg_write(7'd9, 1'b1, 8'h4E); // pin1, wen clear -> ch14
    run_slot(1'b1, 8'h00, 8'h00, a, b, e);
    idle_slots(4);
    run_slot(1'b0, 8'h5A, 8'h11, a, b, e);
    run_slot(1'b0, 8'h22, 8'hC3, a, b, e);
    run_slot(1'b0, 8'h66, 8'h66, a, b, e);
    run_slot(1'b0, 8'h99, 8'h99, a, b, e);
    run_slot(1'b0, 8'h77, 8'h77, a, b, e);
    ch_read(5'd10, d); check("R7 R10 pin1 to ch10", d, 8'h5A);
    ch_read(5'd11, d); check("R7 R10 pin2 to ch11", d, 8'hC3);
    ch_read(5'd12, d); check("R7 loop to ch12", d, 8'h3C);
    ch_read(5'd13, d); check("R8 src off no write", d, 8'h00);
    ch_read(5'd14, d); check("R8 wen clear no write", d, 8'h00);
    idle_slots(22);
  endtask

  task automatic t_cfg_timing();
    logic [7:0] a, b; logic [1:0] e;
    run_slot(1'b1, 8'h00, 8'h00, a, b, e);
    idle_slots(9);
    cfg_write(7'd20, 1'b0, 8'hA1);
    idle_slots(10);
    run_slot(1'b0, 8'h00, 8'h00, a, b, e);
    check("R9 same frame unchanged", {6'd0, e}, 8'h00);
    idle_slots(11);
    run_slot(1'b1, 8'h00, 8'h00, a, b, e);
    idle_slots(19);
    run_slot(1'b0, 8'h00, 8'h00, a, b, e);
    check("R9 next frame oe", {6'd0, e}, 8'h01);
    check("R9 next frame data", a, 8'hA5);
    idle_slots(11);
  endtask

  task automatic t_modes();
    logic [7:0] a, b; logic [1:0] e;
    // frame start by wrap in mode 0
    run_slot(1'b0, 8'h00, 8'h00, a, b, e);
    check("R2 mode0 wrap oe", {6'd0, e}, 8'h01);
    check("R2 mode0 wrap data", a, 8'hA5);
    // sync mid-frame
    idle_slots(2);
    run_slot(1'b1, 8'h00, 8'h00, a, b, e);
    check("R2 fsync mid-frame slot0", {6'd0, e}, 8'h01);
    run_slot(1'b0, 8'h00, 8'h00, a, b, e);
    check("R2 after fsync slot1", {6'd0, e}, 8'h02);
    // mode 1: slot 32 exists
    mode = 2'd1;
    cfg_write(7'd32, 1'b0, 8'hC3);
    run_slot(1'b1, 8'h00, 8'h00, a, b, e);
    idle_slots(31);
    run_slot(1'b0, 8'h00, 8'h00, a, b, e);
    check("R2 mode1 slot32 oe", {6'd0, e}, 8'h02);
    check("R2 mode1 slot32 data", b, 8'h81);
    idle_slots(31);
    run_slot(1'b0, 8'h00, 8'h00, a, b, e);
    check("R2 mode1 wrap at 64", {6'd0, e}, 8'h01);
    // mode 2: slot 64 exists
    mode = 2'd2;
    cfg_write(7'd64, 1'b0, 8'hE4);
    run_slot(1'b1, 8'h00, 8'h00, a, b, e);
    idle_slots(63);
    run_slot(1'b0, 8'h00, 8'h00, a, b, e);
    check("R2 mode2 slot64 oe", {6'd0, e}, 8'h03);
    check("R6 mode2 slot64 both pins", a ^ b, 8'h00);
    check("R3 mode2 slot64 data", a, 8'h7E);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_ni = 1'b1;
    t_reset();
    t_tx_basic();
    t_rx();
    t_cfg_timing();
    t_modes();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule